// File: doc/BRIEF.md
# Serial GFC Nibble Inserter

This block sits in the transmit path of an ATM cell stream. It replaces the Generic Flow Control field of each outbound cell with a value that an external device shifts in over a serial pin. The GFC field is the upper four bits of header byte 0. The cell stream is byte wide, carries a valid qualifier and a start-of-cell marker, and passes through the block with a fixed latency of one cycle.

Every accepted start-of-cell opens a new cell period. If the insertion-enable bit is high at that start-of-cell, the block produces a serial clock of four pulses. Each pulse is one low system cycle followed by one high system cycle. During the first pulse the block also drives a framing output high, which tells the external source that the most significant GFC bit is due. The block samples the serial data input on each rising edge of the serial clock, most significant bit first.

A nibble completed in one cell period goes into the header of the next cell, provided insertion is still enabled at that cell's start. If a nibble was interrupted by an early start-of-cell, it is discarded. The enable bit is examined only at a start-of-cell. HEC recalculation and scrambling take place downstream of this block.

Top module: `gfc_serial_insert`

## Requirements
- R1: `out_valid` and `out_soc` repeat `in_valid` and `in_valid & in_soc` one cycle later.
- R2: Bytes that are not start-of-cell bytes leave the block unchanged, one cycle later. The lower nibble (bits 3..0) of a start-of-cell byte also always passes unchanged.
- R3: Two conditions cause bits 7..4 of the start-of-cell byte to be replaced by the captured nibble: `ins_en` is high at the start-of-cell, and four serial bits were fully captured during the preceding cell period.
- R4: Suppose `ins_en` is low at a start-of-cell. That byte then passes unchanged, and both `ser_clk` and `ser_msb` stay low for the whole cell period.
- R5: Suppose `ins_en` is high at an accepted start-of-cell. Starting in the next cycle, `ser_clk` then runs four periods. Each period is low for one cycle and high for one cycle. After those four periods `ser_clk` stays low. The pulses are counted in system cycles and do not depend on `in_valid`.
- R6: `ser_msb` is high for exactly the two cycles of the first serial bit slot.
- R7: `ser_din` is sampled at the system edge where `ser_clk` rises. The first sampled bit becomes output bit 7, and the last becomes bit 4.
- R8: A start-of-cell that arrives fewer than eight cycles after the previous one abandons the unfinished nibble. No nibble is inserted into that header, and a new serial sequence starts.
- R9: If the previous cell period ran with insertion disabled, the first enabled start-of-cell byte passes unchanged.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `out_soc`, `out_data`, `ser_clk` and `ser_msb` become 0. Changes of `ins_en` away from a start-of-cell have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_en | input | 1 | Insertion enable control bit, sampled at start-of-cell |
| in_valid | input | 1 | Input byte qualifier |
| in_soc | input | 1 | Input byte is header byte 0 |
| in_data | input | DATA_W | Input cell byte |
| ser_din | input | 1 | Serial GFC data, MSB first |
| ser_clk | output | 1 | Serial clock generated by the block |
| ser_msb | output | 1 | Framing pulse marking the MSB slot |
| out_valid | output | 1 | Output byte qualifier |
| out_soc | output | 1 | Output byte is header byte 0 |
| out_data | output | DATA_W | Output cell byte |

## Verification
The cell outputs are due one cycle after the input byte, and the bench compares them at the following falling edge. `ser_clk` and `ser_msb` follow an accepted start-of-cell by one register. The model therefore counts the edges since that start-of-cell and predicts odd counts 1, 3, 5 and 7 as high serial clock and counts 0 and 1 as framing. The bench drives the wanted bit during each low phase and its complement during each high phase. As a result, any sample taken one cycle off the rising edge corrupts the inserted nibble. The inserted nibble is expected at the first start-of-cell that comes at least eight edges after the previous one.

// File: rtl/gfc_pkg.sv
// Package: shared types and constants for the serial GFC inserter.
// Assumes: nothing beyond standard SystemVerilog.
package gfc_pkg;

    // Default widths of a cell byte and of the GFC field.
    localparam int unsigned BYTE_W_DEF = 8;
    localparam int unsigned GFC_W_DEF  = 4;

    // State of the serial capture sequencer.
    typedef enum logic {
        SER_IDLE = 1'b0,
        SER_RUN  = 1'b1
    } ser_state_e;

endpackage

// File: rtl/gfc_ser_engine.sv
// Module: gfc_ser_engine
// Produces the serial clock and MSB framing for one cell period and shifts
// in GFC_W bits, MSB first, on the rising edges of that clock.
// Assumes: start is a single-cycle pulse per accepted start-of-cell; a new
// start abandons any sequence in progress.
module gfc_ser_engine
    import gfc_pkg::*;
#(
    parameter int unsigned GFC_W = GFC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_en,
    input  logic             ser_din,
    output logic             ser_clk,
    output logic             ser_msb,
    output logic [GFC_W-1:0] nib,
    output logic             nib_ok
);

    localparam int unsigned SLOTS = 2 * GFC_W;
    localparam int unsigned PH_W  = $clog2(SLOTS);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOTS - 1);
    localparam logic [PH_W-1:0] PH_MSB_END = PH_W'(2);

    ser_state_e       st;
    logic [PH_W-1:0]  ph;
    logic [GFC_W-1:0] sh;
    logic             done;
    logic             running;

    assign running = (st == SER_RUN);

    // Sequencer: phase counter, shift register and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SER_IDLE;
            ph   <= '0;
            sh   <= '0;
            done <= 1'b0;
        end else if (start) begin
            st   <= start_en ? SER_RUN : SER_IDLE;
            ph   <= '0;
            done <= 1'b0;
        end else if (running) begin
            if (!ph[0]) begin
                sh <= {sh[GFC_W-2:0], ser_din};
            end
            if (ph == PH_LAST) begin
                st   <= SER_IDLE;
                ph   <= '0;
                done <= 1'b1;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // Serial clock and framing decoded from the sequencer registers.
    always_comb begin
        ser_clk = running & ph[0];
        ser_msb = running & (ph < PH_MSB_END);
    end

    // A nibble is available once complete, including the final edge itself.
    always_comb begin
        nib    = sh;
        nib_ok = done | (running & (ph == PH_LAST));
    end

    AST_CLK_HIGH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |=> !ser_clk);                                    // R5
    AST_MSB_SPANS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_msb && !ser_clk && !start) |=> (ser_clk && ser_msb)); // R6
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !start_en) |=> (!ser_clk && !ser_msb));         // R4
    AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && $rose(done)) |-> $past(ser_clk));              // R7

endmodule

// File: rtl/gfc_hdr_mux.sv
// Module: gfc_hdr_mux
// Registers the cell stream and, at start-of-cell with insertion enabled and
// a complete nibble ready, replaces the upper GFC_W bits of the byte.
// Assumes: nib/nib_ok reflect the cell period that ends at this start-of-cell.
module gfc_hdr_mux
    import gfc_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W_DEF,
    parameter int unsigned GFC_W  = GFC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ins_en,
    input  logic [GFC_W-1:0]  nib,
    input  logic              nib_ok,
    output logic              out_valid,
    output logic              out_soc,
    output logic [DATA_W-1:0] out_data
);

    localparam int unsigned KEEP_W = DATA_W - GFC_W;

    logic              do_ins;
    logic [DATA_W-1:0] nxt_data;

    // Decide whether this byte receives the captured nibble.
    always_comb begin
        do_ins   = in_valid & in_soc & ins_en & nib_ok;
        nxt_data = do_ins ? {nib, in_data[KEEP_W-1:0]} : in_data;
    end

    // Output pipeline register: fixed single-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_soc   <= in_valid & in_soc;
            out_data  <= nxt_data;
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_soc == $past(in_soc)));    // R1
    AST_BODY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_soc) |=> out_data == $past(in_data));   // R2
    AST_LOW_NIB_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_data[KEEP_W-1:0] == $past(in_data[KEEP_W-1:0])); // R2
    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc && !ins_en) |=> out_data == $past(in_data)); // R4
    AST_NO_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_soc && !nib_ok) |=> out_data == $past(in_data)); // R8

endmodule

// File: rtl/gfc_serial_insert.sv
// Module: gfc_serial_insert (top)
// Inserts an externally shifted GFC nibble into header byte 0 of each cell.
// Assumes: at least 2*GFC_W cycles between accepted start-of-cell markers for
// a nibble to complete; ins_en is only looked at on start-of-cell bytes.
module gfc_serial_insert
    import gfc_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W_DEF,
    parameter int unsigned GFC_W  = GFC_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ser_din,
    output logic              ser_clk,
    output logic              ser_msb,
    output logic              out_valid,
    output logic              out_soc,
    output logic [DATA_W-1:0] out_data
);

    logic             cell_start;
    logic [GFC_W-1:0] nib;
    logic             nib_ok;

    // An accepted start-of-cell opens a new cell period.
    always_comb cell_start = in_valid & in_soc;

    gfc_ser_engine #(.GFC_W(GFC_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cell_start),
        .start_en (ins_en),
        .ser_din  (ser_din),
        .ser_clk  (ser_clk),
        .ser_msb  (ser_msb),
        .nib      (nib),
        .nib_ok   (nib_ok)
    );

    gfc_hdr_mux #(.DATA_W(DATA_W), .GFC_W(GFC_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_soc    (in_soc),
        .in_data   (in_data),
        .ins_en    (ins_en),
        .nib       (nib),
        .nib_ok    (nib_ok),
        .out_valid (out_valid),
        .out_soc   (out_soc),
        .out_data  (out_data)
    );

    AST_FRAMING_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_start && ins_en) |=> (ser_msb && !ser_clk));        // R6

endmodule

// File: tb/tb_gfc_serial_insert.sv
`timescale 1ns/1ps
module tb_gfc_serial_insert;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ins_en = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_soc = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       ser_din = 1'b0;
    logic       ser_clk, ser_msb, out_valid, out_soc;
    logic [7:0] out_data;

    always #2.5 clk = ~clk;

    gfc_serial_insert dut (
        .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .in_valid(in_valid),
        .in_soc(in_soc), .in_data(in_data), .ser_din(ser_din),
        .ser_clk(ser_clk), .ser_msb(ser_msb), .out_valid(out_valid),
        .out_soc(out_soc), .out_data(out_data)
    );

    int   ncmp = 0;
    int   nerr = 0;
    bit   done = 0;

    // Behavioural reference state
    int         t = 8;         // edges since last accepted start-of-cell
    bit         en_per = 0;    // serial sequence active for this period
    logic [3:0] cap = 4'h0;
    int         ncap = 0;
    logic [3:0] send_nib = 4'h0;
    bit         exp_ov = 0, exp_os = 0;
    logic [7:0] exp_od = 8'h00;
    string      tag = "R2";
    logic [7:0] lcg = 8'h5a;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        ncmp++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit s, input logic [7:0] d, input bit en);
        logic sd;
        bit   avail;
        sd = 1'b1;
        if (en_per && t < 8)
            sd = (t % 2 == 0) ? send_nib[3 - t/2] : ~send_nib[3 - (t-1)/2];
        in_valid = v; in_soc = s; in_data = d; ins_en = en; ser_din = sd;
        @(posedge clk);
        avail  = (ncap == 4);
        exp_ov = v;
        exp_os = v && s;
        if (v) begin
            if (s && en && avail) begin
                exp_od = {cap, d[3:0]}; tag = "R3 R7";
            end else begin
                exp_od = d;
                tag = !s ? "R2" : (!en ? "R4" : (ncap > 0 ? "R8" : "R9"));
            end
        end
        if (v && s) begin
            en_per = en; t = 0; ncap = 0;
        end else begin
            if (en_per && t < 8 && t % 2 == 0) begin
                cap[3 - t/2] = sd; ncap++;
            end
            if (t < 8) t++;
        end
        @(negedge clk);
        chk(out_valid == exp_ov, "R1", "out_valid", {7'd0, out_valid}, {7'd0, exp_ov});
        chk(out_soc == exp_os, "R1", "out_soc", {7'd0, out_soc}, {7'd0, exp_os});
        if (exp_ov) chk(out_data == exp_od, tag, "out_data", out_data, exp_od);
        chk(ser_clk == (en_per && t < 8 && t % 2 == 1), en_per ? "R5" : "R4", "ser_clk",
            {7'd0, ser_clk}, {7'd0, (en_per && t < 8 && t % 2 == 1)});
        chk(ser_msb == (en_per && t < 2), en_per ? "R6" : "R4", "ser_msb",
            {7'd0, ser_msb}, {7'd0, (en_per && t < 2)});
    endtask

    // One cell of len cycles; gaps drops valid on some body cycles,
    // flip drives the inverse enable on non-start cycles (R10 ignore check).
    task automatic send_cell(input int len, input bit en, input logic [3:0] nib,
                             input bit gaps, input bit flip);
        for (int i = 0; i < len; i++) begin
            bit v;
            lcg = lcg * 8'd37 + 8'd11;
            v = (i == 0) || !gaps || (i % 3 != 2);
            step(v, i == 0, lcg, (i == 0) ? en : (flip ? ~en : en));
            if (i == 0) send_nib = nib;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, ins_en);
    endtask

    initial begin
        for (int k = 0; k < 150000; k++) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
            $finish;
        end
    end

    initial begin
        // R10: reset with busy inputs
        rst_n = 1'b0; in_valid = 1'b1; in_soc = 1'b1; in_data = 8'hff; ins_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid", {7'd0, out_valid}, 8'h00);
        chk(out_soc == 1'b0, "R10", "out_soc", {7'd0, out_soc}, 8'h00);
        chk(out_data == 8'h00, "R10", "out_data", out_data, 8'h00);
        chk(ser_clk == 1'b0, "R10", "ser_clk", {7'd0, ser_clk}, 8'h00);
        chk(ser_msb == 1'b0, "R10", "ser_msb", {7'd0, ser_msb}, 8'h00);
        rst_n = 1'b1; in_valid = 1'b0; in_soc = 1'b0;
        idle(2);
        // R4 / R2: insertion disabled
        for (int c = 0; c < 3; c++) send_cell(12, 1'b0, 4'ha, 1'b0, 1'b0);
        // R9 then R3: first enabled cell passes, following ones get nibbles
        send_cell(12, 1'b1, 4'h9, 1'b0, 1'b0);
        send_cell(12, 1'b1, 4'h6, 1'b0, 1'b0);
        send_cell(12, 1'b1, 4'h1, 1'b0, 1'b0);
        send_cell(12, 1'b1, 4'h8, 1'b0, 1'b0);
        // Minimum period of eight cycles (R3, R5)
        for (int c = 0; c < 4; c++) send_cell(8, 1'b1, 4'(c * 5 + 3), 1'b0, 1'b0);
        // Valid gaps do not stall the serial pulses (R5)
        send_cell(14, 1'b1, 4'hc, 1'b1, 1'b0);
        send_cell(14, 1'b1, 4'h3, 1'b1, 1'b0);
        // Short periods abandon the nibble (R8)
        send_cell(5, 1'b1, 4'hf, 1'b0, 1'b0);
        send_cell(7, 1'b1, 4'h5, 1'b0, 1'b0);
        send_cell(10, 1'b1, 4'he, 1'b0, 1'b0);
        send_cell(10, 1'b1, 4'h2, 1'b0, 1'b0);
        // Mid-cell enable changes ignored (R10), disable at boundary (R4)
        send_cell(12, 1'b1, 4'hb, 1'b0, 1'b1);
        send_cell(12, 1'b0, 4'h7, 1'b0, 1'b1);
        send_cell(12, 1'b1, 4'h4, 1'b0, 1'b0);
        idle(5);
        // Mixed sequence
        for (int c = 0; c < 40; c++) begin
            lcg = lcg * 8'd37 + 8'd11;
            send_cell(5 + (lcg % 12), (lcg[6:5] != 2'b00), lcg[3:0] ^ 4'(c), lcg[7], lcg[4]);
        end
        idle(10);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

endmodule